// File: doc/BRIEF.md
# ADC Conversion Interrupt Pulse Timer

This block reproduces the cycle timing of a single analog-to-digital conversion as the surrounding trigger and interrupt logic sees it. A start pulse, accepted only while the block is idle, opens a sample/hold window of a configurable number of cycles. The input word is frozen at the end of that window. A conversion phase of a configurable number of cycles then follows, and at its end the frozen word is written into the result register.

An interrupt pulse one cycle wide marks each conversion. The pulse can mark completion, or it can be placed early. In the early position it comes a programmed number of cycles after the hold window closes, so that a consumer can begin its preparatory work before the data is ready. When the programmed delay would land at or past completion, the pulse is moved to the completion cycle. Starts that arrive while a conversion is in progress are dropped, and each one raises a sticky flag.

The lengths, the mode and the delay are captured when a start is accepted. A typical setting is a 42-cycle conversion with an early pulse delayed by 20 cycles.

Top module: `adc_pulse_timer`

## Requirements
- R1: After reset, `irq_o`, `busy_o` and `missed_o` are 0 and `result_o` is all zeros.
- R2: A start (`start_i`=1) seen at a clock edge while `busy_o`=0 is accepted. `busy_o` is 1 from that edge until the edge A+N edges later, where A is the acquisition length and N is the conversion length.
- R3: `sample_i` is captured at the last acquisition edge (edge A after acceptance). `result_o` takes the captured value at edge A+N, the same edge at which `busy_o` falls, and holds it until the next completion.
- R4: With `early_i`=0, `irq_o` is high for the single cycle that follows completion edge A+N.
- R5: With `early_i`=1 and delay D < N, `irq_o` is high for the single cycle following edge A+D. With D=0, this edge is the one that closes acquisition.
- R6: With `early_i`=1 and D >= N, the pulse is moved to completion edge A+N.
- R7: Each accepted conversion produces exactly one `irq_o` pulse, and the pulse is never longer than one cycle.
- R8: A start seen while `busy_o`=1 is ignored, and this includes the completion edge. It sets `missed_o`, which stays 1 until reset, and it leaves the timing and the result of the running conversion unchanged.
- R9: `acq_len_i`, `conv_len_i`, `early_i` and `delay_i` are sampled at acceptance. Changes to them during a conversion have no effect on that conversion.
- R10: An acquisition or conversion length of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-conversion request |
| acq_len_i | input | ACQ_W (8) | Sample/hold window length, in cycles |
| conv_len_i | input | CONV_W (8) | Conversion length, in cycles |
| early_i | input | 1 | 1 = early pulse position, 0 = end-of-conversion position |
| delay_i | input | DLY_W (8) | Early-pulse delay after end of acquisition |
| sample_i | input | DATA_W (12) | Sample data to be converted |
| result_o | output | DATA_W (12) | Result register |
| irq_o | output | 1 | Single-cycle interrupt pulse |
| busy_o | output | 1 | Conversion in progress |
| missed_o | output | 1 | Sticky flag for dropped starts |

## Verification
Two pairs of events can fall on the same edge. The first is the completion of a conversion (result update, busy falling, and possibly the pulse) together with a fresh start request. The bench drives a start exactly on the completion edge. It checks that the start is dropped, that `missed_o` rises, that `busy_o` stays low in the following cycle, and that the pulse and the result still appear as computed. The second is an early pulse with zero delay, or one clamped to completion, landing on a phase boundary. These cases are judged by the exact cycle of the pulse, which the bench computes from A, N and D.

// File: rtl/adc_pulse_pkg.sv
package adc_pulse_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_CONV = 2'd2
  } phase_e;
endpackage

// File: rtl/adc_phase_seq.sv
module adc_phase_seq
  import adc_pulse_pkg::*;
#(
  parameter int ACQ_W  = 8,
  parameter int CONV_W = 8,
  localparam int CNT_W = (ACQ_W > CONV_W) ? ACQ_W : CONV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ACQ_W-1:0]  acq_len_i,
  input  logic [CONV_W-1:0] conv_len_i,
  output logic              accept_o,
  output logic              acq_end_o,
  output logic              conv_done_o,
  output logic              in_conv_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CONV_W-1:0] conv_last_o,
  output logic              busy_o,
  output logic              missed_o
);
  phase_e            state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ACQ_W-1:0]  acq_last_q, acq_last_d;
  logic [CONV_W-1:0] conv_last_q, conv_last_d;
  logic              missed_q, missed_d;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    acq_last_d  = acq_last_q;
    conv_last_d = conv_last_q;
    accept_o    = start_i && (state_q == PH_IDLE);
    acq_end_o   = (state_q == PH_ACQ)  && (cnt_q == CNT_W'(acq_last_q));
    conv_done_o = (state_q == PH_CONV) && (cnt_q == CNT_W'(conv_last_q));
    missed_d    = missed_q | (start_i && (state_q != PH_IDLE));
    unique case (state_q)
      PH_IDLE: if (accept_o) begin
        state_d     = PH_ACQ;
        cnt_d       = '0;
        acq_last_d  = (acq_len_i == '0)  ? '0 : acq_len_i - ACQ_W'(1);
        conv_last_d = (conv_len_i == '0) ? '0 : conv_len_i - CONV_W'(1);
      end
      PH_ACQ: begin
        if (acq_end_o) begin
          state_d = PH_CONV;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PH_CONV: begin
        if (conv_done_o) begin
          state_d = PH_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PH_IDLE;
      cnt_q       <= '0;
      acq_last_q  <= '0;
      conv_last_q <= '0;
      missed_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      missed_q <= missed_d;
      if (accept_o) begin
        acq_last_q  <= acq_last_d;
        conv_last_q <= conv_last_d;
      end
    end
  end

  assign in_conv_o   = (state_q == PH_CONV);
  assign cnt_o       = cnt_q;
  assign conv_last_o = conv_last_q;
  assign busy_o      = (state_q != PH_IDLE);
  assign missed_o    = missed_q;

  // R2: an accepted start makes the block busy on the next cycle
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  // R8: a start while busy raises the sticky flag
  p_drop_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> missed_o);
  // R8: the flag never clears without reset
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    missed_o |=> missed_o);
endmodule

// File: rtl/adc_irq_sel.sv
module adc_irq_sel #(
  parameter int DLY_W  = 8,
  parameter int CONV_W = 8,
  parameter int CNT_W  = 8,
  localparam int MX_W  = (DLY_W > CONV_W) ? DLY_W : CONV_W,
  localparam int CMP_W = ((MX_W > CNT_W) ? MX_W : CNT_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              early_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic              acq_end_i,
  input  logic              conv_done_i,
  input  logic              in_conv_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CONV_W-1:0] conv_last_i,
  input  logic              busy_i,
  output logic              irq_o
);
  logic             early_q;
  logic [DLY_W-1:0] dly_q;
  logic             irq_q, irq_d;
  logic             too_late, hit_early, hit_done;

  always_comb begin
    too_late  = CMP_W'(dly_q) > CMP_W'(conv_last_i);
    hit_early = early_q && !too_late &&
                (((dly_q == '0) && acq_end_i) ||
                 ((dly_q != '0) && in_conv_i &&
                  (CMP_W'(cnt_i) == CMP_W'(dly_q - DLY_W'(1)))));
    hit_done  = conv_done_i && (!early_q || too_late);
    irq_d     = hit_early || hit_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_q <= 1'b0;
      dly_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (accept_i) begin
        early_q <= early_i;
        dly_q   <= delay_i;
      end
    end
  end

  assign irq_o = irq_q;

  // R7: pulse lasts one cycle only
  p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  // R4: a pulse only follows an edge at which a conversion was running
  p_pulse_in_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(busy_i));
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_end_i,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] held_q, res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      res_q  <= '0;
    end else begin
      if (acq_end_i)   held_q <= sample_i;
      if (conv_done_i) res_q  <= held_q;
    end
  end

  assign result_o = res_q;
endmodule

// File: rtl/adc_pulse_timer.sv
module adc_pulse_timer #(
  parameter int ACQ_W  = 8,
  parameter int CONV_W = 8,
  parameter int DLY_W  = 8,
  parameter int DATA_W = 12,
  localparam int CNT_W = (ACQ_W > CONV_W) ? ACQ_W : CONV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ACQ_W-1:0]  acq_len_i,
  input  logic [CONV_W-1:0] conv_len_i,
  input  logic              early_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] result_o,
  output logic              irq_o,
  output logic              busy_o,
  output logic              missed_o
);
  logic              accept, acq_end, conv_done, in_conv;
  logic [CNT_W-1:0]  cnt;
  logic [CONV_W-1:0] conv_last;

  adc_phase_seq #(.ACQ_W(ACQ_W), .CONV_W(CONV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .acq_len_i(acq_len_i), .conv_len_i(conv_len_i),
    .accept_o(accept), .acq_end_o(acq_end), .conv_done_o(conv_done),
    .in_conv_o(in_conv), .cnt_o(cnt), .conv_last_o(conv_last),
    .busy_o(busy_o), .missed_o(missed_o)
  );

  adc_irq_sel #(.DLY_W(DLY_W), .CONV_W(CONV_W), .CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .early_i(early_i),
    .delay_i(delay_i), .acq_end_i(acq_end), .conv_done_i(conv_done),
    .in_conv_i(in_conv), .cnt_i(cnt), .conv_last_i(conv_last),
    .busy_i(busy_o), .irq_o(irq_o)
  );

  adc_result_hold #(.DATA_W(DATA_W)) u_res (
    .clk(clk), .rst_n(rst_n), .acq_end_i(acq_end), .conv_done_i(conv_done),
    .sample_i(sample_i), .result_o(result_o)
  );

  // R3: the result only changes on the edge where busy falls
  p_result_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> ($fell(busy_o)));
endmodule

// File: tb/adc_pulse_timer_tb_top.sv
module adc_pulse_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  acq_len_i, conv_len_i, delay_i;
  logic        early_i;
  logic [11:0] sample_i;
  logic [11:0] result_o;
  logic        irq_o, busy_o, missed_o;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  adc_pulse_timer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .acq_len_i(acq_len_i),
    .conv_len_i(conv_len_i), .early_i(early_i), .delay_i(delay_i),
    .sample_i(sample_i), .result_o(result_o), .irq_o(irq_o),
    .busy_o(busy_o), .missed_o(missed_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start_i = 0; acq_len_i = 4; conv_len_i = 6;
    early_i = 0; delay_i = 0; sample_i = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  // One conversion; scramble=1 changes configuration mid-run (R9);
  // late_at>0 pulses start at that edge index (R8).
  task automatic run_conv(input string tag, input int a, input int n,
                          input bit early, input int d, input int s1,
                          input bit scramble, input int late_at,
                          input int prev_res);
    int ae, ne, fire, irq_cnt;
    ae = (a == 0) ? 1 : a;
    ne = (n == 0) ? 1 : n;
    fire = (!early || d >= ne) ? ae + ne : ae + d;
    irq_cnt = 0;
    acq_len_i = 8'(a); conv_len_i = 8'(n); early_i = early;
    delay_i = 8'(d); sample_i = 12'(s1); start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    if (scramble) begin
      acq_len_i = 8'd50; conv_len_i = 8'd3; early_i = ~early; delay_i = 8'd1;
    end
    if (late_at == 1) start_i = 1'b1;
    for (int c = 1; c <= ae + ne + 3; c++) begin
      @(posedge clk); #1;
      start_i = (late_at == c + 1);
      if (c == ae) sample_i = 12'(s1 ^ 12'hFFF);
      chk({tag, " R2 busy"}, busy_o, (c < ae + ne) ? 1 : 0);
      chk({tag, " R4/R5/R6 irq"}, irq_o, (c == fire) ? 1 : 0);
      if (irq_o) irq_cnt++;
      if (c < ae + ne) chk({tag, " R3 result held"}, result_o, prev_res);
      else             chk({tag, " R3 result"}, result_o, s1);
    end
    chk({tag, " R7 pulse count"}, irq_cnt, 1);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<20000", wd);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic t_reset();
    chk("R1 irq", irq_o, 0); chk("R1 busy", busy_o, 0);
    chk("R1 missed", missed_o, 0); chk("R1 result", result_o, 0);
  endtask

  task automatic t_normal();
    run_conv("normal", 4, 6, 0, 0, 12'h123, 0, 0, 0);
    run_conv("normal42", 3, 42, 0, 20, 12'hA5A, 0, 0, 12'h123);
  endtask

  task automatic t_early();
    run_conv("early20 R5", 5, 42, 1, 20, 12'h3C3, 0, 0, 12'hA5A);
    run_conv("early0 R5", 4, 6, 1, 0, 12'h001, 0, 0, 12'h3C3);
    run_conv("earlyN-1 R5", 2, 6, 1, 5, 12'h7FF, 0, 0, 12'h001);
  endtask

  task automatic t_clamp();
    run_conv("clampEq R6", 3, 6, 1, 6, 12'h0F0, 0, 0, 12'h7FF);
    run_conv("clampBig R6", 3, 6, 1, 200, 12'h00F, 0, 0, 12'h0F0);
  endtask

  task automatic t_zero_len();
    run_conv("zero R10", 0, 0, 0, 0, 12'h555, 0, 0, 12'h00F);
    run_conv("zeroEarly R10", 0, 4, 1, 0, 12'h2AA, 0, 0, 12'h555);
  endtask

  task automatic t_config_latch();
    run_conv("latch R9", 4, 8, 1, 3, 12'h321, 1, 0, 12'h2AA);
    chk("R8 no missed yet", missed_o, 0);
  endtask

  task automatic t_missed();
    run_conv("missMid R8", 4, 6, 0, 0, 12'h111, 0, 5, 12'h321);
    chk("R8 missed set", missed_o, 1);
    do_reset();
    t_reset();
    run_conv("missDone R8", 4, 6, 1, 2, 12'h222, 0, 10, 0);
    chk("R8 missed at completion", missed_o, 1);
    repeat (3) @(posedge clk);
    #1 chk("R8 still idle", busy_o, 0);
    chk("R8 sticky", missed_o, 1);
    chk("R3 result kept", result_o, 12'h222);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_normal();
    t_early();
    t_clamp();
    t_zero_len();
    t_config_latch();
    t_missed();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule